// File: doc/BRIEF.md
# Write-Once Configuration Register

This block holds one 8-bit configuration byte for a microcontroller-style chip. The CPU reaches it over a simple bus with an address, a write strobe, write data, a read strobe and read data. The register answers at one fixed address.

The first write to that address after reset is stored. The same clock edge sets a lock flag. Any later write is dropped without notice until the next reset. Each stored bit also drives a control output to another module:

- PWM alignment mode
- Top-side PWM output polarity
- Bottom-side PWM output polarity
- Independent-mode select
- Low-voltage-detect power enable
- Low-voltage reset enable
- Watchdog disable

Because software can set these controls only once per reset, a runaway program cannot change them after start-up.

Top module: `cfg_once_reg`

## Requirements
- R1: While reset is asserted and right after it is released, the stored byte, every field output, `locked` and `bus_rdata` are all 0.
- R2: A write (`bus_wr`=1) to address 0x1F while `locked` is 0 loads the byte on that clock edge. `locked` goes to 1 on the same edge.
- R3: While `locked` is 1, writes to 0x1F leave the stored byte unchanged. Only a reset clears `locked`, and after a reset the next write is accepted again.
- R4: An accepted write whose data is 0x00 still sets `locked`.
- R5: Bit 1 is not implemented. It always reads as 0 and ignores written data.
- R6: The field outputs follow the stored bits as listed below. For both polarity bits, 1 means negative polarity.

  | Bit | Output | Meaning when 1 |
  |-----|--------|----------------|
  | 7 | `pwm_edge_align` | edge-aligned (0 means center-aligned) |
  | 6 | `pwm_bot_neg` | negative polarity, bottom side |
  | 5 | `pwm_top_neg` | negative polarity, top side |
  | 4 | `pwm_indep` | independent mode |
  | 3 | `lvd_rst_en` | low-voltage reset enabled |
  | 2 | `lvd_pwr_en` | low-voltage-detect power enabled |
  | 0 | `wdog_dis` | watchdog disabled |

- R7: With `bus_rd`=1 and address 0x1F, `bus_rdata` shows the stored byte in the same cycle, whatever the lock state. Otherwise `bus_rdata` is 0. Reads never change `locked`.
- R8: Writes to any address other than 0x1F change neither the stored byte nor `locked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| locked | output | 1 | Set once the allowed write has been taken |
| pwm_edge_align | output | 1 | PWM alignment select, 1 means edge-aligned |
| pwm_bot_neg | output | 1 | Bottom-side PWM negative polarity |
| pwm_top_neg | output | 1 | Top-side PWM negative polarity |
| pwm_indep | output | 1 | Independent PWM mode select |
| lvd_rst_en | output | 1 | Low-voltage reset enable |
| lvd_pwr_en | output | 1 | Low-voltage-detect power enable |
| wdog_dis | output | 1 | Watchdog disable |

## Verification
The bench goes after the cases that a lock implemented the wrong way would miss:

- **Second write.** A design that keeps accepting writes would overwrite the first value.
- **All-zero write.** A design that derives the lock from nonzero data would leave the register open.
- **Address alias.** The bench writes to 0x9F and 0x3F. A design with a partial address decode would accept one of them.
- **Unimplemented bit.** A design that stores bit 1 would read it back as 1.
- **Re-arm after reset.** The bench checks that a new write is accepted after reset. A design that fails to clear the lock would stay frozen.
- **Reads before any write.** The bench reads first and then writes. A design where reads touch the lock would wrongly reject that write.

// File: rtl/cfg_once_reg.sv
module cfg_once_reg #(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h1F,
  parameter logic [7:0]  IMPL_MASK = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              locked,
  output logic              pwm_edge_align,
  output logic              pwm_bot_neg,
  output logic              pwm_top_neg,
  output logic              pwm_indep,
  output logic              lvd_rst_en,
  output logic              lvd_pwr_en,
  output logic              wdog_dis
);

  logic [7:0] cfg_q;
  logic       hit;
  logic       take;

  assign hit  = (bus_addr == REG_ADDR);
  assign take = bus_wr && hit && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      locked <= 1'b0;
    end else if (take) begin
      cfg_q  <= bus_wdata & IMPL_MASK;
      locked <= 1'b1;
    end
  end

  assign bus_rdata      = (bus_rd && hit) ? cfg_q : 8'h00;
  assign pwm_edge_align = cfg_q[7];
  assign pwm_bot_neg    = cfg_q[6];
  assign pwm_top_neg    = cfg_q[5];
  assign pwm_indep      = cfg_q[4];
  assign lvd_rst_en     = cfg_q[3];
  assign lvd_pwr_en     = cfg_q[2];
  assign wdog_dis       = cfg_q[0];

  // R2
  accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && !locked) |=> (locked && cfg_q == ($past(bus_wdata) & IMPL_MASK)));

  // R3
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(cfg_q)));

  // R8
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> ($stable(cfg_q) && $stable(locked)));

  // R5
  unimpl_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[1]);

  // R7
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && hit) |-> (bus_rdata == 8'h00));

  // R7
  read_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !bus_wr) |=> !locked);

endmodule

// File: tb/cfg_once_reg_tb_top.sv
module cfg_once_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       locked;
  logic pwm_edge_align, pwm_bot_neg, pwm_top_neg, pwm_indep;
  logic lvd_rst_en, lvd_pwr_en, wdog_dis;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cfg_once_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .locked(locked), .pwm_edge_align(pwm_edge_align), .pwm_bot_neg(pwm_bot_neg),
    .pwm_top_neg(pwm_top_neg), .pwm_indep(pwm_indep), .lvd_rst_en(lvd_rst_en),
    .lvd_pwr_en(lvd_pwr_en), .wdog_dis(wdog_dis)
  );

  // {lock_exp, addr, wdata, stored_exp}
  localparam logic [24:0] VEC [0:5] = '{
    {1'b0, 8'h1E, 8'hFF, 8'h00},
    {1'b0, 8'h3F, 8'hAA, 8'h00},
    {1'b1, 8'h1F, 8'hA7, 8'hA5},
    {1'b1, 8'h1F, 8'h5A, 8'hA5},
    {1'b1, 8'h1F, 8'h00, 8'hA5},
    {1'b1, 8'h9F, 8'hFF, 8'hA5}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] fields();
    return {pwm_edge_align, pwm_bot_neg, pwm_top_neg, pwm_indep,
            lvd_rst_en, lvd_pwr_en, 1'b0, wdog_dis};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk);
    // R1 during reset
    check("R1 lock in reset", {7'b0, locked}, 8'h00);
    check("R1 fields in reset", fields(), 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(8'h1F, v);
    check("R1 readback after reset", v, 8'h00);

    // R2 R3 R5 R8 vector walk
    foreach (VEC[i]) begin
      do_write(VEC[i][23:16], VEC[i][15:8]);
      do_read(8'h1F, v);
      check($sformatf("R2/R3/R5/R8 vec%0d data", i), v, VEC[i][7:0]);
      check($sformatf("R2/R3/R8 vec%0d lock", i), {7'b0, locked}, {7'b0, VEC[i][24]});
    end
    // R6 field positions for A5
    check("R6 fields A5", fields(), 8'hA5);
    // R7 gating of read data
    bus_addr = 8'h1F; bus_rd = 1'b0; #1;
    check("R7 no strobe", bus_rdata, 8'h00);
    do_read(8'h1E, v);
    check("R7 other addr read", v, 8'h00);

    // R1 reset clears everything
    do_reset();
    check("R1 fields after re-reset", fields(), 8'h00);
    check("R1 lock after re-reset", {7'b0, locked}, 8'h00);

    // R4 zero write locks
    do_write(8'h1F, 8'h00);
    check("R4 zero write lock", {7'b0, locked}, 8'h01);
    do_write(8'h1F, 8'hFF);
    do_read(8'h1F, v);
    check("R4 locked after zero write", v, 8'h00);

    // R7 reads leave the lock open
    do_reset();
    repeat (3) begin
      @(negedge clk);
      do_read(8'h1F, v);
    end
    check("R7 reads keep lock clear", {7'b0, locked}, 8'h00);
    // R3 re-armed after reset, R5 bit1 masked, R6 all fields
    do_write(8'h1F, 8'hFF);
    do_read(8'h1F, v);
    check("R3 re-armed write / R5", v, 8'hFD);
    check("R6 fields FD", fields(), 8'hFD);
    check("R6 wdog bit0", {7'b0, wdog_dis}, 8'h01);
    // R7 readback while locked
    do_write(8'h1F, 8'h12);
    do_read(8'h1F, v);
    check("R7 readback while locked", v, 8'hFD);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule